// File: doc/BRIEF.md
# Receive Character Queue with Line Status and Idle Timeout

This block sits between a serial receiver and a host. Each assembled character arrives with three error flags (parity, framing, break). The block keeps them together in one queue entry of eleven bits. The oldest entry is shown to the host at all times as the holding byte, and its error flags appear on the line-status bits in the same cycle. A host read strobe retires that entry, and the next one, with its own flags, takes its place at once.

A data-ready interrupt tells the host when to come and read. In queue mode it fires when the fill count reaches a level chosen by a 2-bit field. In single-entry mode it fires whenever a character is held. Data may be left below the level while the line is idle. For that case, an idle timer counts bit-time ticks. It raises the interrupt after four character times at the programmed word length plus twelve bit-times, so that the data is still collected.

The character input is a valid/ready stream without back-pressure. The serial source cannot stall, so `in_ready` is only advisory. A character presented while `in_ready` is low is discarded and reported as an overrun. Control and status pins are plain levels.

Top module: `rcv_buffer_top`

## Requirements
- R1: After reset the queue is empty: `data_ready`, `rx_irq` and `rx_timeout` are low, `err_flags` is zero and `in_ready` is high.
- R2: Entries leave in arrival order. While `data_ready` is high, `hold_data` shows the oldest entry's data byte.
- R3: A read strobe while `data_ready` is high retires the head entry at the next clock edge. A read strobe while empty has no effect.
- R4: Line-status bits come from the entry at the head: `err_flags[1]` = parity (`in_flags[0]`), `err_flags[2]` = framing (`in_flags[1]`), `err_flags[3]` = break (`in_flags[2]`). They change in the same cycle the head changes, and they are zero while empty.
- R5: A character presented while the queue is full is dropped and `err_flags[0]` (overrun) is high from the next cycle. It clears on the next read that retires an entry, unless another drop happens in that same cycle.
- R6: With `fifo_en` low the capacity is one entry. With `fifo_en` high the capacity is DEPTH entries. `in_ready` is low exactly when the current capacity is used up.
- R7: A change of `fifo_en` empties the queue at the next edge and clears overrun and the timer. Any character presented in that cycle is lost.
- R8: In queue mode, a level condition holds when the fill is at least the selected level: `trig_sel` 0→1, 1→DEPTH/8, 2→DEPTH/4, 3→DEPTH−8. In single-entry mode the level condition is simply "data held".
- R9: In queue mode with data held, the timer counts `baud_tick` pulses. Any accepted character or retiring read restarts it. After 4·(`word_len`+7)+12 ticks, `rx_timeout` rises in the cycle after the last tick. It is cleared by an accepted character, a retiring read, an empty queue or single-entry mode. `word_len` 0..3 stands for 5..8 data bits, and start and stop bits are counted.
- R10: `rx_irq` = `irq_en` AND (level condition OR `rx_timeout`), evaluated combinationally from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Character strobe from the receiver |
| in_ready | output | 1 | Space available (advisory) |
| in_data | input | 8 | Received data byte |
| in_flags | input | 3 | {break, framing, parity} for this byte |
| rd_strobe | input | 1 | Host read of the holding byte |
| fifo_en | input | 1 | 1 = queue mode, 0 = single-entry mode |
| trig_sel | input | 2 | Interrupt fill level select |
| word_len | input | 2 | Data bits minus five |
| baud_tick | input | 1 | One pulse per bit-time |
| irq_en | input | 1 | Data-ready interrupt enable |
| hold_data | output | 8 | Oldest byte (valid when data_ready) |
| data_ready | output | 1 | At least one entry held |
| err_flags | output | 4 | {break, framing, parity, overrun} |
| rx_timeout | output | 1 | Idle timeout pending |
| rx_irq | output | 1 | Data-ready interrupt |

## Verification
The bench builds the block with DEPTH = 16, which makes the fill levels 1, 2, 4 and 8. It also puts the full-queue overrun path within reach of a few dozen writes. All four word lengths are exercised, and the timeout windows of 40 to 52 ticks expire many times within the run. A long random phase mixes drops, reads on an empty queue, mode toggles with data held, and sparse ticks. Every cycle of it is compared against a queue-based model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       cap_one,
  input  logic                       wr_en,
  input  rxq_entry_t                 wr_entry,
  input  logic                       rd_req,
  output rxq_entry_t                 head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       accepted,
  output logic                       advanced,
  output logic                       dropped
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full     = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign accepted = wr_en & ~full;
  assign advanced = rd_req & (count != '0);
  assign dropped  = wr_en & full;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accepted && !flush) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accepted) wr_ptr <= wr_ptr + AW'(1);
      if (advanced) rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(accepted) - CW'(advanced);
    end
  end

  // R6: fill never exceeds the queue size
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5: a drop without a read leaves the fill unchanged
  a_r5_drop_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped && !advanced && !flush) |=> count == $past(count));
  // R3: a retiring read alone lowers the fill by one
  a_r3_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (advanced && !accepted && !flush) |=> count == $past(count) - CW'(1));
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int BASE_BITS = 7,
  parameter int WORDS     = 4,
  parameter int EXTRA     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       baud_tick,
  input  logic [1:0] word_len,
  output logic       tmo
);
  localparam int MAXL = WORDS * (BASE_BITS + 3) + EXTRA;
  localparam int TW   = $clog2(MAXL + 1);

  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;

  assign limit = TW'(WORDS) * (TW'(BASE_BITS) + TW'(word_len)) + TW'(EXTRA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else if (!run || restart) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else if (baud_tick && !tmo) begin
      cnt <= cnt + TW'(1);
      if (cnt == limit - TW'(1)) tmo <= 1'b1;
    end
  end

  // R9: the timeout only starts on a bit-time tick
  a_r9_tmo_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> $past(baud_tick));
  // R9: the tick count stays within the window
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/rcv_buffer_top.sv
module rcv_buffer_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [2:0] in_flags,
  input  logic       rd_strobe,
  input  logic       fifo_en,
  input  logic [1:0] trig_sel,
  input  logic [1:0] word_len,
  input  logic       baud_tick,
  input  logic       irq_en,
  output logic [7:0] hold_data,
  output logic       data_ready,
  output logic [3:0] err_flags,
  output logic       rx_timeout,
  output logic       rx_irq
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] LVL0 = CW'(1);
  localparam logic [CW-1:0] LVL1 = CW'(DEPTH / 8);
  localparam logic [CW-1:0] LVL2 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] LVL3 = CW'(DEPTH - 8);

  rxq_entry_t    wr_entry, head;
  logic [CW-1:0] count, level;
  logic          full, accepted, advanced, dropped;
  logic          prev_en, flush, ovr, lvl_hit;

  assign flush    = fifo_en != prev_en;
  assign wr_entry = '{brk: in_flags[2], frm: in_flags[1], par: in_flags[0], data: in_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap_one(~fifo_en),
    .wr_en(in_valid), .wr_entry(wr_entry), .rd_req(rd_strobe),
    .head(head), .count(count), .full(full),
    .accepted(accepted), .advanced(advanced), .dropped(dropped)
  );

  rxq_timeout u_tmo (
    .clk(clk), .rst_n(rst_n),
    .run(fifo_en & (count != '0) & ~flush),
    .restart(accepted | advanced),
    .baud_tick(baud_tick), .word_len(word_len), .tmo(rx_timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en <= fifo_en;
      ovr     <= 1'b0;
    end else begin
      prev_en <= fifo_en;
      if (flush)         ovr <= 1'b0;
      else if (dropped)  ovr <= 1'b1;
      else if (advanced) ovr <= 1'b0;
    end
  end

  always_comb begin
    unique case (trig_sel)
      2'd0:    level = LVL0;
      2'd1:    level = LVL1;
      2'd2:    level = LVL2;
      default: level = LVL3;
    endcase
    lvl_hit = fifo_en ? (count >= level) : (count != '0);
  end

  assign in_ready   = ~full;
  assign data_ready = count != '0;
  assign hold_data  = head.data;
  assign err_flags  = {data_ready ? {head.brk, head.frm, head.par} : 3'b000, ovr};
  assign rx_irq     = irq_en & (lvl_hit | (fifo_en & rx_timeout));

  // R5: a drop outside a flush shows overrun next cycle
  a_r5_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !flush) |=> err_flags[0]);
  // R7: a mode change leaves the queue empty
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_ready);
endmodule

// File: tb/rcv_buffer_top_tb_top.sv
module rcv_buffer_top_tb_top;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, rd_strobe = 0, fifo_en = 1, baud_tick = 0, irq_en = 1;
  logic [7:0] in_data = 0;
  logic [2:0] in_flags = 0;
  logic [1:0] trig_sel = 0, word_len = 3;
  logic in_ready, data_ready, rx_timeout, rx_irq;
  logic [7:0] hold_data;
  logic [3:0] err_flags;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rcv_buffer_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_flags(in_flags), .rd_strobe(rd_strobe),
    .fifo_en(fifo_en), .trig_sel(trig_sel), .word_len(word_len),
    .baud_tick(baud_tick), .irq_en(irq_en), .hold_data(hold_data),
    .data_ready(data_ready), .err_flags(err_flags), .rx_timeout(rx_timeout),
    .rx_irq(rx_irq)
  );

  // Reference model
  logic [10:0] q[$];
  bit m_ovr, m_tmo, m_prev, m_acc, m_adv, m_drop;
  int m_cnt, m_sz, m_cap, m_lim;

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return DEPTH / 8;
      2'd2: return DEPTH / 4;
      default: return DEPTH - 8;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ovr = 0; m_cnt = 0; m_tmo = 0; m_prev = fifo_en;
    end else if (fifo_en != m_prev) begin
      m_prev = fifo_en; q.delete(); m_ovr = 0; m_cnt = 0; m_tmo = 0;
    end else begin
      m_sz = q.size(); m_cap = fifo_en ? DEPTH : 1;
      m_acc = in_valid && m_sz < m_cap;
      m_drop = in_valid && m_sz >= m_cap;
      m_adv = rd_strobe && m_sz > 0;
      m_lim = 4 * (int'(word_len) + 7) + 12;
      if (!(fifo_en && m_sz > 0) || m_acc || m_adv) begin
        m_cnt = 0; m_tmo = 0;
      end else if (baud_tick && !m_tmo) begin
        if (m_cnt == m_lim - 1) m_tmo = 1;
        m_cnt++;
      end
      if (m_adv) void'(q.pop_front());
      if (m_acc) q.push_back({in_flags, in_data});
      if (m_drop) m_ovr = 1;
      else if (m_adv) m_ovr = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, one time unit after each edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      automatic bit er = q.size() > 0;
      automatic bit ei;
      automatic logic [3:0] ef = {er ? q[0][10:8] : 3'b000, m_ovr};
      ei = irq_en && (fifo_en ? (q.size() >= lvl(trig_sel) || m_tmo) : er);
      chk(data_ready === er, "R3 data_ready", data_ready, er);
      if (er) chk(hold_data === q[0][7:0], "R2 hold_data", hold_data, q[0][7:0]);
      chk(err_flags[3:1] === ef[3:1], "R4 err_flags[3:1]", err_flags[3:1], ef[3:1]);
      chk(err_flags[0] === ef[0], "R5 overrun", err_flags[0], ef[0]);
      chk(in_ready === (q.size() < (fifo_en ? DEPTH : 1)), "R6 in_ready", in_ready,
          q.size() < (fifo_en ? DEPTH : 1));
      chk(rx_timeout === m_tmo, "R9 rx_timeout", rx_timeout, m_tmo);
      chk(rx_irq === ei, "R8 R10 rx_irq", rx_irq, ei);
    end
  end

  task automatic step(input bit v, input bit rd, input bit tk);
    @(negedge clk);
    in_valid = v; rd_strobe = rd; baud_tick = tk;
    in_data = 8'($urandom); in_flags = 3'($urandom);
    @(posedge clk);
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, (i % 3) == 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!data_ready && !rx_irq && !rx_timeout && err_flags == 0 && in_ready,
        "R1 reset state", {data_ready, rx_irq, rx_timeout, err_flags, in_ready}, 1);
    @(negedge clk); rst_n = 1;
    // R2 R4: ordered writes with flags, then reads
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    step(0, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 1, 0);
    // R8: level 4 of 16
    trig_sel = 2;
    for (int i = 0; i < 5; i++) step(1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 1, 0);
    // R5: overflow then drain
    trig_sel = 3;
    for (int i = 0; i < DEPTH + 4; i++) step(1, 0, 0);
    step(1, 1, 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0);
    // R9: timeout at every word length
    for (int w = 0; w < 4; w++) begin
      word_len = 2'(w);
      step(1, 0, 0); step(1, 0, 0);
      idle_ticks(200);
      step(0, 1, 1);
      idle_ticks(180);
      step(0, 1, 0);
    end
    // R10: interrupt disabled
    irq_en = 0; trig_sel = 0;
    step(1, 0, 0); idle_ticks(20); step(0, 1, 0);
    irq_en = 1;
    // R6: single-entry mode
    @(negedge clk); fifo_en = 0;
    step(0, 0, 0);
    step(1, 0, 0); step(1, 0, 0); step(1, 1, 0); step(0, 1, 0); step(0, 1, 0);
    // R7: flush with data held
    @(negedge clk); fifo_en = 1;
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    @(negedge clk); fifo_en = 0;
    step(1, 0, 0); step(0, 0, 0);
    @(negedge clk); fifo_en = 1;
    step(0, 0, 0);
    // Random mix
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 499) == 0) fifo_en = ~fifo_en;
      if ($urandom_range(0, 99) == 0) trig_sel = 2'($urandom);
      if ($urandom_range(0, 199) == 0) word_len = 2'($urandom);
      if ($urandom_range(0, 299) == 0) irq_en = ~irq_en;
      in_valid = ($urandom_range(0, 9) < ((i / 1000) % 2 ? 6 : 2));
      rd_strobe = ($urandom_range(0, 9) < ((i / 1000) % 2 ? 2 : 5));
      baud_tick = ($urandom_range(0, 3) == 0);
      in_data = 8'($urandom); in_flags = 3'($urandom);
      @(posedge clk);
    end
    step(0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule